// File: doc/BRIEF.md
# Five-Source Vectored Interrupt Controller

This block gathers five interrupt request sources into a register of pending flags. Beside it sits an enable register. Software reads and writes both registers over a byte-wide bus made of an address, write data, a write strobe and combinational read data. Peripherals set individual flags with per-source raise inputs and clear them with per-source lower inputs.

The controller forms a request to the CPU from the enabled pending sources, gated by a master-enable input that the CPU drives. In the same cycle it presents the fixed vector address of the highest-priority enabled pending source. When the CPU accepts the request it pulses an acknowledge. That pulse clears only the selected flag, so any other pending source is served on a later request. A separate query port reports whether any enabled pending source falls inside a caller-supplied source mask.

Top module: `icu_top`

## Requirements
- R1: After reset the enable register reads 0x00, the flag register reads 0xE1 (only source 0 pending), and the request output is low.
- R2: A bus write to address 0xFFFF stores all eight data bits in the enable register. Bits 4..0 are the per-source enables and bits 7..5 are plain storage. A read of 0xFFFF returns exactly what was written, so 0x12 reads back as 0x12 and 0xFF as 0xFF.
- R3: A read of address 0xFF0F returns the five pending flags in bits 4..0 (source i in bit i) and ones in bits 7..5. A write to 0xFF0F loads all five flags directly from data bits 4..0.
- R4: A read of any other address returns 0xFF. A write to any other address changes neither register.
- R5: The query output is high exactly when (enables AND flags AND query mask) is nonzero over bits 4..0. With every enable clear, a pending flag does not raise it.
- R6: The request output is high when at least one enabled source is pending and the master-enable input is high. The vector output is valid in the same cycle and does not depend on master-enable.
- R7: Among the enabled pending sources the lowest bit index wins. The vector is 0x40 + 8*index (0x40, 0x48, 0x50, 0x58, 0x60), and 0x00 when no enabled source is pending.
- R8: An acknowledge pulse clears, at the next clock edge, only the flag of the source selected in that cycle. With no enabled source pending it changes nothing.
- R9: A raise pulse sets its flag at the next clock edge. It takes precedence over a simultaneous flag-register write, lower pulse or acknowledge that would clear the same bit.
- R10: A lower pulse clears its flag at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| src_raise | input | 5 | Per-source set pulse |
| src_lower | input | 5 | Per-source clear pulse |
| master_en | input | 1 | CPU master enable; gates irq_req |
| irq_ack | input | 1 | CPU acknowledge of the presented vector |
| query_mask | input | 5 | Source mask for query_hit |
| query_hit | output | 1 | Some enabled pending source lies within query_mask |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vector | output | 8 | Vector address of the selected source |

## Verification
The hardest situations to reach are the collisions on one flag bit in a single edge. These are a raise together with a flag-register write of zero, a raise together with a lower, and a raise together with an acknowledge of that same source. The bench drives these pulses inside one cycle through its step task and then reads the flag register back over the bus. It also uses an acknowledge while two sources are pending, followed by a read-back, to show that the lower-priority flag survives and then becomes the new vector.

// File: rtl/icu_pkg.sv
package icu_pkg;

    typedef struct packed {
        logic [4:0] flags;
    } icu_flag_state_t;

    typedef struct packed {
        logic [7:0] en;
    } icu_en_state_t;

endpackage

// File: rtl/icu_flag_bank.sv
module icu_flag_bank #(
    parameter int unsigned NUM_SRC = 5,
    parameter logic [NUM_SRC-1:0] RESET_PEND = 5'b00001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [NUM_SRC-1:0] load_data,
    input  logic [NUM_SRC-1:0] clr_mask,
    input  logic [NUM_SRC-1:0] set_mask,
    output logic [NUM_SRC-1:0] flag_q
);

    logic [NUM_SRC-1:0] flag_d;
    logic [NUM_SRC-1:0] flag_r;

    // Precedence: bus load, then clears, then sets (sets win).
    always_comb begin
        flag_d = flag_r;
        if (load_en) begin
            flag_d = load_data;
        end
        flag_d = flag_d & ~clr_mask;
        flag_d = flag_d | set_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_r <= RESET_PEND;
        end else begin
            flag_r <= flag_d;
        end
    end

    assign flag_q = flag_r;

endmodule

// File: rtl/icu_prio_sel.sv
module icu_prio_sel #(
    parameter int unsigned NUM_SRC    = 5,
    parameter int unsigned VEC_W      = 8,
    parameter int unsigned VEC_BASE   = 8'h40,
    parameter int unsigned VEC_STRIDE = 8
) (
    input  logic [NUM_SRC-1:0] active,
    output logic [NUM_SRC-1:0] sel_oh,
    output logic               any,
    output logic [VEC_W-1:0]   vector
);

    logic [NUM_SRC:0] seen;

    assign seen[0] = 1'b0;

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_chain
        assign seen[gi+1]  = seen[gi] | active[gi];
        assign sel_oh[gi]  = active[gi] & ~seen[gi];
    end

    assign any = seen[NUM_SRC];

    always_comb begin
        vector = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel_oh[i]) begin
                vector = vector | VEC_W'(VEC_BASE + i * VEC_STRIDE);
            end
        end
    end

endmodule

// File: rtl/icu_top.sv
module icu_top #(
    parameter int unsigned NUM_SRC    = 5,
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned DATA_W     = 8,
    parameter logic [ADDR_W-1:0] EN_ADDR   = 16'hFFFF,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 16'hFF0F,
    parameter int unsigned VEC_BASE   = 8'h40,
    parameter int unsigned VEC_STRIDE = 8,
    parameter logic [NUM_SRC-1:0] RESET_PEND = 5'b00001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_we,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] src_raise,
    input  logic [NUM_SRC-1:0] src_lower,
    input  logic               master_en,
    input  logic               irq_ack,
    input  logic [NUM_SRC-1:0] query_mask,
    output logic               query_hit,
    output logic               irq_req,
    output logic [DATA_W-1:0]  irq_vector
);

    localparam int unsigned PAD_W = DATA_W - NUM_SRC;

    logic [DATA_W-1:0]  en_d;
    logic [DATA_W-1:0]  en_q;
    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] active;
    logic [NUM_SRC-1:0] sel_oh;
    logic [NUM_SRC-1:0] ack_clr;
    logic               any_active;
    logic               hit_en;
    logic               hit_flag;

    assign hit_en   = bus_we && (bus_addr == EN_ADDR);
    assign hit_flag = bus_we && (bus_addr == FLAG_ADDR);

    // Enable register: all DATA_W bits stored.
    always_comb begin
        en_d = en_q;
        if (hit_en) begin
            en_d = bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    assign active  = en_q[NUM_SRC-1:0] & flag_q;
    assign ack_clr = irq_ack ? sel_oh : '0;

    icu_flag_bank #(
        .NUM_SRC    (NUM_SRC),
        .RESET_PEND (RESET_PEND)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (hit_flag),
        .load_data (bus_wdata[NUM_SRC-1:0]),
        .clr_mask  (ack_clr | src_lower),
        .set_mask  (src_raise),
        .flag_q    (flag_q)
    );

    icu_prio_sel #(
        .NUM_SRC    (NUM_SRC),
        .VEC_W      (DATA_W),
        .VEC_BASE   (VEC_BASE),
        .VEC_STRIDE (VEC_STRIDE)
    ) u_prio (
        .active (active),
        .sel_oh (sel_oh),
        .any    (any_active),
        .vector (irq_vector)
    );

    assign irq_req   = any_active & master_en;
    assign query_hit = |(active & query_mask);

    always_comb begin
        if (bus_addr == EN_ADDR) begin
            bus_rdata = en_q;
        end else if (bus_addr == FLAG_ADDR) begin
            bus_rdata = {{PAD_W{1'b1}}, flag_q};
        end else begin
            bus_rdata = '1;
        end
    end

endmodule

// File: rtl/icu_checker.sv
module icu_checker #(
    parameter int unsigned NUM_SRC    = 5,
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned DATA_W     = 8,
    parameter logic [ADDR_W-1:0] EN_ADDR   = 16'hFFFF,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 16'hFF0F,
    parameter int unsigned VEC_BASE   = 8'h40,
    parameter int unsigned VEC_STRIDE = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_SRC-1:0] src_raise,
    input logic               master_en,
    input logic               irq_ack,
    input logic               irq_req,
    input logic [DATA_W-1:0]  irq_vector,
    input logic [NUM_SRC-1:0] flag_q,
    input logic [NUM_SRC-1:0] sel_oh,
    input logic [DATA_W-1:0]  en_q
);

    assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |-> !irq_req);

    assert_vec_grid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (int'(irq_vector) >= VEC_BASE
                     && int'(irq_vector) < VEC_BASE + NUM_SRC * VEC_STRIDE
                     && ((int'(irq_vector) - VEC_BASE) % VEC_STRIDE) == 0));

    assert_sel_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_oh));

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && (|sel_oh) && !bus_we) |=> ((flag_q & $past(sel_oh & ~src_raise)) == '0));

    assert_raise_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_raise) |=> ((flag_q & $past(src_raise)) == $past(src_raise)));

    assert_flag_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == FLAG_ADDR) |-> (bus_rdata[DATA_W-1:NUM_SRC] == '1));

    assert_other_ff_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != FLAG_ADDR && bus_addr != EN_ADDR) |-> (bus_rdata == '1));

    assert_other_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr != EN_ADDR) |=> $stable(en_q));

endmodule

bind icu_top icu_checker #(
    .NUM_SRC    (NUM_SRC),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .EN_ADDR    (EN_ADDR),
    .FLAG_ADDR  (FLAG_ADDR),
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_rdata  (bus_rdata),
    .src_raise  (src_raise),
    .master_en  (master_en),
    .irq_ack    (irq_ack),
    .irq_req    (irq_req),
    .irq_vector (irq_vector),
    .flag_q     (flag_q),
    .sel_oh     (sel_oh),
    .en_q       (en_q)
);

// File: tb/tb_icu_top.sv
module tb_icu_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_we;
    logic [7:0]  bus_rdata;
    logic [4:0]  src_raise;
    logic [4:0]  src_lower;
    logic        master_en;
    logic        irq_ack;
    logic [4:0]  query_mask;
    logic        query_hit;
    logic        irq_req;
    logic [7:0]  irq_vector;

    always #10 clk = ~clk;

    icu_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_we     (bus_we),
        .bus_rdata  (bus_rdata),
        .src_raise  (src_raise),
        .src_lower  (src_lower),
        .master_en  (master_en),
        .irq_ack    (irq_ack),
        .query_mask (query_mask),
        .query_hit  (query_hit),
        .irq_req    (irq_req),
        .irq_vector (irq_vector)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // {we, addr, wdata, raise, ack, exp_rdata, exp_irq, exp_vector}
    localparam int NSTEP = 12;
    localparam logic [47:0] STEPS [NSTEP] = '{
        {1'b1, 16'hFFFF, 8'h12, 5'h00, 1'b0, 8'h12, 1'b0, 8'h00},
        {1'b1, 16'hFFFF, 8'hFF, 5'h00, 1'b0, 8'hFF, 1'b1, 8'h40},
        {1'b1, 16'hFF0F, 8'h0A, 5'h00, 1'b0, 8'hEA, 1'b1, 8'h48},
        {1'b0, 16'hFF0F, 8'h00, 5'h00, 1'b1, 8'hE8, 1'b1, 8'h58},
        {1'b0, 16'hFF0F, 8'h00, 5'h10, 1'b0, 8'hF8, 1'b1, 8'h58},
        {1'b0, 16'hFF0F, 8'h00, 5'h00, 1'b1, 8'hF0, 1'b1, 8'h60},
        {1'b1, 16'hFF0F, 8'h00, 5'h04, 1'b0, 8'hE4, 1'b1, 8'h50},
        {1'b1, 16'hFFFF, 8'h10, 5'h00, 1'b0, 8'h10, 1'b0, 8'h00},
        {1'b0, 16'h1234, 8'h00, 5'h00, 1'b0, 8'hFF, 1'b0, 8'h00},
        {1'b1, 16'h1234, 8'h00, 5'h00, 1'b0, 8'hFF, 1'b0, 8'h00},
        {1'b0, 16'hFFFF, 8'h00, 5'h00, 1'b0, 8'h10, 1'b0, 8'h00},
        {1'b1, 16'hFF0F, 8'h1F, 5'h00, 1'b0, 8'hFF, 1'b1, 8'h60}
    };
    localparam string TAGS [NSTEP] = '{
        "R2", "R2 R7", "R3 R7", "R8", "R9", "R8", "R9", "R2 R6", "R4", "R4", "R4", "R3"
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [15:0] a, input logic [7:0] d,
                        input logic [4:0] r, input logic [4:0] l, input logic k);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d;
        src_raise = r; src_lower = l; irq_ack = k;
        @(posedge clk);
        #1;
        bus_we = 1'b0; src_raise = '0; src_lower = '0; irq_ack = 1'b0;
        #1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_addr = 16'hFFFF; bus_wdata = '0; bus_we = 1'b0;
        src_raise = '0; src_lower = '0; master_en = 1'b1; irq_ack = 1'b0;
        query_mask = 5'h1F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 reset state
        bus_addr = 16'hFFFF; #1;
        check("R1 enable", bus_rdata, 8'h00);
        bus_addr = 16'hFF0F; #1;
        check("R1 flags", bus_rdata, 8'hE1);
        check("R1 irq", irq_req, 1'b0);
        check("R5 no enables", query_hit, 1'b0);

        // Vector table walk
        for (int i = 0; i < NSTEP; i++) begin
            logic [47:0] e;
            e = STEPS[i];
            step(e[47], e[46:31], e[30:23], e[22:18], 5'h00, e[17]);
            check({TAGS[i], " rdata"}, bus_rdata, e[16:9]);
            check({TAGS[i], " irq"}, irq_req, e[8]);
            check({TAGS[i], " vector"}, irq_vector, e[7:0]);
        end
        // state: enable 0x10, flags 0x1F

        // R6 master gating: request drops, vector stays
        master_en = 1'b0; #1;
        check("R6 gated irq", irq_req, 1'b0);
        check("R6 vector kept", irq_vector, 8'h60);
        master_en = 1'b1; #1;

        // R5 query mask
        query_mask = 5'h0F; #1;
        check("R5 mask miss", query_hit, 1'b0);
        query_mask = 5'h10; #1;
        check("R5 mask hit", query_hit, 1'b1);
        query_mask = 5'h1F;
        step(1'b1, 16'hFFFF, 8'h00, 5'h00, 5'h00, 1'b0);
        check("R5 all disabled", query_hit, 1'b0);
        check("R6 all disabled", irq_req, 1'b0);

        // R10 lower
        step(1'b1, 16'hFFFF, 8'h1F, 5'h00, 5'h00, 1'b0);
        step(1'b0, 16'hFF0F, 8'h00, 5'h00, 5'h01, 1'b0);
        check("R10 lower", bus_rdata, 8'hFE);
        check("R7 next vector", irq_vector, 8'h48);

        // R9 raise beats lower
        step(1'b0, 16'hFF0F, 8'h00, 5'h01, 5'h01, 1'b0);
        check("R9 raise vs lower", bus_rdata, 8'hFF);

        // R9 raise beats acknowledge of same source
        step(1'b0, 16'hFF0F, 8'h00, 5'h01, 5'h00, 1'b1);
        check("R9 raise vs ack", bus_rdata, 8'hFF);

        // R8 acknowledge with nothing enabled
        step(1'b1, 16'hFFFF, 8'hE0, 5'h00, 5'h00, 1'b0);
        check("R2 upper bits only", bus_rdata, 8'hE0);
        step(1'b0, 16'hFF0F, 8'h00, 5'h00, 5'h00, 1'b1);
        check("R8 idle ack", bus_rdata, 8'hFF);
        check("R7 idle vector", irq_vector, 8'h00);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule